// File: doc/BRIEF.md
# Logarithmic-Term Fixed-Point Accumulator

This block takes a stream of base-2 logarithmic words, one per clock under a valid strobe, and turns each word into a signed fixed-point term. It then adds that term into a 64-bit running total. It sits at the end of an interaction-sum pipeline, where pairwise results come out in log form and must be summed with full fixed-point precision.

The fractional bits of the exponent select a mantissa from a table inside the block. The integer bits of the exponent shift that mantissa into place. The converter and the accumulator each take two register stages. A clear request travels down the pipeline alongside the data, so a new total can begin on any cycle without draining the pipeline first. A completion flag tells the reader when the last accepted term has reached the total.

Top module: `log_fix_accum`

## Requirements
- R1: The input word has five fields. Bit 16 is the sign (1 = negative). Bit 15 is the nonzero flag. Bits 14:8 are an unsigned integer exponent e. Bits 7:0 are a fraction f. The magnitude of the term is floor(M(f) * 2^e / 256), where M(f) = round(256 * 2^(f/256)) and lies in the range 256..511.
- R2: A word accepted at a rising edge shows up in `total` right after the third rising edge that follows. A new word may be accepted at every edge.
- R3: A valid word whose nonzero flag is 0 adds nothing to the total, whatever its other bits are.
- R4: A word with the sign bit set is subtracted. The total is a 64-bit two's-complement value that wraps modulo 2^64.
- R5: When `restart` is high at the same edge as a valid word, that term replaces the old total. When `restart` is high with no valid word, the total becomes 0. The total changes at the same latency as in R2.
- R6: A nonzero word with e >= 56 is clamped to magnitude 2^56-1 and sets `overflow`. The `overflow` flag stays set until a restart. At a restart, it takes the clamp state of the term that comes in with the restart.
- R7: `done` rises right after the fourth rising edge following the last valid word. It stays low while any accepted word is still in flight. It stays low after a restart until a new word is accepted.
- R8: After a synchronous active-low reset, `total` is 0 and both `overflow` and `done` are 0.
- R9: A word presented while `in_valid` is low has no effect on `total`, `overflow` or `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_word` this cycle |
| in_word | input | 17 | Logarithmic word: sign, nonzero flag, exponent, fraction |
| restart | input | 1 | Begin a new total |
| total | output | 64 | Running two's-complement sum |
| overflow | output | 1 | Sticky clamp indicator |
| done | output | 1 | All accepted words have reached `total` |

## Verification
A word sampled at edge t changes `total` and `overflow` only at edge t+3, and `done` is due at edge t+4. The bench holds a three-entry queue of pending contributions, one entry per edge: it pushes every input, valid or not, and pops the entry from three edges earlier. A separate four-cycle countdown gives the expected completion flag. Inputs are driven on the falling edge, and all three outputs are compared against the model on every falling edge, so every expected value lines up with the edge that is meant to produce it.

// File: rtl/lfa_pkg.sv
// Shared constants, control type and mantissa-table generator for the
// logarithmic-term accumulator. Assumes real arithmetic is legal in
// elaboration-time constant functions.
package lfa_pkg;

    localparam int LFA_LOG_W      = 17;
    localparam int LFA_FRAC_W     = 8;
    localparam int LFA_MANT_W     = 8;
    localparam int LFA_TERM_W     = 57;
    localparam int LFA_SUM_W      = 64;
    localparam int LFA_CVT_STAGES = 2;
    localparam int LFA_ACC_STAGES = 2;

    // Control bits that ride alongside data through every stage
    typedef struct packed {
        logic vld;
        logic clr;
    } lfa_ctl_t;

    // Mantissa (implicit one included) for 2^(idx / 2^frac_w), scaled by 2^mant_w
    function automatic int lut_mant(int idx, int frac_w, int mant_w);
        real ratio;
        ratio = $pow(2.0, real'(idx) / real'(1 << frac_w));
        return $rtoi(ratio * real'(1 << mant_w) + 0.5);
    endfunction

endpackage

// File: rtl/lfa_mant_rom.sv
// Mantissa table: maps a fraction of the exponent to the stored mantissa bits
// (the leading one is implicit). Contents are computed at elaboration.
// Assumes 2^FRAC_W entries of MANT_W bits each; read is combinational.
module lfa_mant_rom #(
    parameter int FRAC_W = lfa_pkg::LFA_FRAC_W,
    parameter int MANT_W = lfa_pkg::LFA_MANT_W
) (
    input  logic [FRAC_W-1:0] addr,
    output logic [MANT_W-1:0] mant
);
    localparam int DEPTH = 1 << FRAC_W;

    logic [MANT_W-1:0] table_q [DEPTH];

    // One constant entry per fraction code
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam int FULL = lfa_pkg::lut_mant(g, FRAC_W, MANT_W);
        assign table_q[g] = FULL[MANT_W-1:0];
    end

    assign mant = table_q[addr];

endmodule

// File: rtl/lfa_converter.sv
// Two-stage log-to-fixed converter. Stage 1 splits the word and looks up the
// mantissa; stage 2 shifts it by the integer exponent and clamps at the
// magnitude range. Output is sign-magnitude plus a clamp flag.
// Assumes word layout {sign, nonzero, exponent, fraction}.
module lfa_converter #(
    parameter int LOG_W  = lfa_pkg::LFA_LOG_W,
    parameter int FRAC_W = lfa_pkg::LFA_FRAC_W,
    parameter int MANT_W = lfa_pkg::LFA_MANT_W,
    parameter int TERM_W = lfa_pkg::LFA_TERM_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic                  in_clr,
    input  logic [LOG_W-1:0]      in_word,
    output lfa_pkg::lfa_ctl_t     out_ctl,
    output logic                  out_sign,
    output logic [TERM_W-2:0]     out_mag,
    output logic                  out_sat
);
    localparam int EXP_W = LOG_W - 2 - FRAC_W;
    localparam int MAG_W = TERM_W - 1;
    localparam int SH_W  = MAG_W + MANT_W;

    lfa_pkg::lfa_ctl_t  s1_ctl;
    logic               s1_sign;
    logic               s1_nz;
    logic [EXP_W-1:0]   s1_exp;
    logic [MANT_W:0]    s1_mant;
    logic [MANT_W-1:0]  rom_mant;

    logic [SH_W-1:0]    shifted;
    logic               sat_c;
    logic [MAG_W-1:0]   mag_c;

    lfa_mant_rom #(.FRAC_W(FRAC_W), .MANT_W(MANT_W)) u_rom (
        .addr (in_word[FRAC_W-1:0]),
        .mant (rom_mant)
    );

    // Stage 1: capture fields and looked-up mantissa
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_ctl  <= '0;
            s1_sign <= 1'b0;
            s1_nz   <= 1'b0;
            s1_exp  <= '0;
            s1_mant <= '0;
        end else begin
            s1_ctl  <= '{vld: in_vld, clr: in_clr};
            s1_sign <= in_word[LOG_W-1];
            s1_nz   <= in_word[LOG_W-2];
            s1_exp  <= in_word[LOG_W-3:FRAC_W];
            s1_mant <= {1'b1, rom_mant};
        end
    end

    // Shift mantissa into place and decide clamping
    always_comb begin
        shifted = SH_W'(s1_mant) << s1_exp;
        sat_c   = s1_nz && (int'(s1_exp) >= MAG_W);
        if (!s1_nz)
            mag_c = '0;
        else if (sat_c)
            mag_c = '1;
        else
            mag_c = MAG_W'(shifted >> MANT_W);
    end

    // Stage 2: register the fixed-point term
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_ctl  <= '0;
            out_sign <= 1'b0;
            out_mag  <= '0;
            out_sat  <= 1'b0;
        end else begin
            out_ctl  <= s1_ctl;
            out_sign <= s1_sign;
            out_mag  <= mag_c;
            out_sat  <= s1_ctl.vld & sat_c;
        end
    end

    AST_ZERO_FLAG_NO_MAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_word[LOG_W-2]) |=> ##1 (out_mag == '0)); // R3

    AST_CLAMP_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_word[LOG_W-2] && (int'(in_word[LOG_W-3:FRAC_W]) >= MAG_W))
        |=> ##1 (out_sat && (&out_mag))); // R6

endmodule

// File: rtl/lfa_accum.sv
// Two-stage signed accumulator. Stage A turns the sign-magnitude term into a
// two's-complement addend; stage B adds it or restarts the total. Holds the
// sticky clamp flag. Assumes addend is zero whenever the valid bit is low.
module lfa_accum #(
    parameter int MAG_W = lfa_pkg::LFA_TERM_W - 1,
    parameter int SUM_W = lfa_pkg::LFA_SUM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lfa_pkg::lfa_ctl_t  in_ctl,
    input  logic               in_sign,
    input  logic [MAG_W-1:0]   in_mag,
    input  logic               in_sat,
    output logic [SUM_W-1:0]   sum,
    output logic               ovf
);
    lfa_pkg::lfa_ctl_t  a_ctl;
    logic [SUM_W-1:0]   a_val;
    logic               a_sat;
    logic [SUM_W-1:0]   ext;

    assign ext = SUM_W'(in_mag);

    // Stage A: apply sign, zero the addend for idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_ctl <= '0;
            a_val <= '0;
            a_sat <= 1'b0;
        end else begin
            a_ctl <= in_ctl;
            a_val <= !in_ctl.vld ? '0 : (in_sign ? (~ext + 1'b1) : ext);
            a_sat <= in_ctl.vld & in_sat;
        end
    end

    // Stage B: accumulate or restart, update sticky clamp flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
            ovf <= 1'b0;
        end else if (a_ctl.clr) begin
            sum <= a_val;
            ovf <= a_sat;
        end else begin
            sum <= sum + a_val;
            ovf <= ovf | a_sat;
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !a_ctl.clr) |=> ovf); // R6

    AST_RESTART_ALONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ctl.clr && !a_ctl.vld) |=> (sum == '0)); // R5

    AST_IDLE_HOLDS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_ctl.vld && !a_ctl.clr) |=> $stable(sum)); // R9

endmodule

// File: rtl/lfa_drain.sv
// Completion tracker: counts down the pipeline depth after each accepted word
// and flags completion once the count is spent. A restart with no word
// withdraws the flag until the next accepted word.
module lfa_drain #(
    parameter int DEPTH = lfa_pkg::LFA_CVT_STAGES + lfa_pkg::LFA_ACC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic in_clr,
    output logic done
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt;
    logic             started;

    // Reload on every accepted word, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            started <= 1'b0;
        end else begin
            if (in_vld)
                cnt <= CNT_W'(DEPTH);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
            if (in_vld)
                started <= 1'b1;
            else if (in_clr)
                started <= 1'b0;
        end
    end

    assign done = started && (cnt == '0);

    AST_DONE_LOW_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> !done); // R7

endmodule

// File: rtl/log_fix_accum.sv
// Top level: log word -> fixed-point term -> 64-bit running total, with a
// restart path, sticky clamp flag and completion flag. One word per clock.
module log_fix_accum #(
    parameter int LOG_W  = lfa_pkg::LFA_LOG_W,
    parameter int FRAC_W = lfa_pkg::LFA_FRAC_W,
    parameter int MANT_W = lfa_pkg::LFA_MANT_W,
    parameter int TERM_W = lfa_pkg::LFA_TERM_W,
    parameter int SUM_W  = lfa_pkg::LFA_SUM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LOG_W-1:0]  in_word,
    input  logic              restart,
    output logic [SUM_W-1:0]  total,
    output logic              overflow,
    output logic              done
);
    localparam int MAG_W = TERM_W - 1;
    localparam int DRAIN = lfa_pkg::LFA_CVT_STAGES + lfa_pkg::LFA_ACC_STAGES;

    lfa_pkg::lfa_ctl_t  cv_ctl;
    logic               cv_sign;
    logic [MAG_W-1:0]   cv_mag;
    logic               cv_sat;

    lfa_converter #(
        .LOG_W(LOG_W), .FRAC_W(FRAC_W), .MANT_W(MANT_W), .TERM_W(TERM_W)
    ) u_cvt (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_valid),
        .in_clr   (restart),
        .in_word  (in_word),
        .out_ctl  (cv_ctl),
        .out_sign (cv_sign),
        .out_mag  (cv_mag),
        .out_sat  (cv_sat)
    );

    lfa_accum #(.MAG_W(MAG_W), .SUM_W(SUM_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_ctl  (cv_ctl),
        .in_sign (cv_sign),
        .in_mag  (cv_mag),
        .in_sat  (cv_sat),
        .sum     (total),
        .ovf     (overflow)
    );

    lfa_drain #(.DEPTH(DRAIN)) u_drn (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_valid),
        .in_clr (restart),
        .done   (done)
    );

    AST_DONE_TOTAL_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(total)); // R7

endmodule

// File: tb/sim_log_fix_accum.sv
`timescale 1ns/1ps
module sim_log_fix_accum;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [16:0] in_word = '0;
    logic        restart = 1'b0;
    logic [63:0] total;
    logic        overflow;
    logic        done;

    log_fix_accum u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .restart(restart), .total(total), .overflow(overflow), .done(done)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic        vld;
        logic        clr;
        logic [63:0] val;
        logic        sat;
    } ev_t;

    ev_t         pipe_q[$];
    logic [63:0] m_sum;
    logic        m_ovf;
    int          m_cnt;
    logic        m_started;
    int          n_vec = 0;
    int          n_fail = 0;
    string       phase = "R8";
    logic        finished = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    function automatic logic [16:0] mk(input logic s, input logic nz, input int e, input int f);
        return {s, nz, 7'(e), 8'(f)};
    endfunction

    // Expected contribution of a word, from the R1/R3/R4/R6 formulas
    function automatic ev_t contrib(input logic v, input logic [16:0] w, input logic c);
        ev_t r;
        int e, f, m;
        logic [63:0] mag;
        r.vld = v; r.clr = c; r.val = '0; r.sat = 1'b0;
        if (v && w[15]) begin
            e = int'(w[14:8]);
            f = int'(w[7:0]);
            m = $rtoi($pow(2.0, f / 256.0) * 256.0 + 0.5);
            if (e >= 56) begin
                mag = (64'd1 << 56) - 64'd1;
                r.sat = 1'b1;
            end else begin
                mag = (64'(m) << e) >> 8;
            end
            r.val = w[16] ? (64'd0 - mag) : mag;
        end
        return r;
    endfunction

    task automatic model_edge(input ev_t ev);
        ev_t h;
        h = pipe_q.pop_front();
        if (h.clr) begin
            m_sum = h.val;
            m_ovf = h.sat;
        end else begin
            m_sum = m_sum + h.val;
            m_ovf = m_ovf | h.sat;
        end
        pipe_q.push_back(ev);
        if (ev.vld) m_cnt = 4;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        if (ev.vld) m_started = 1'b1;
        else if (ev.clr) m_started = 1'b0;
    endtask

    task automatic compare();
        logic exp_done;
        exp_done = m_started && (m_cnt == 0);
        n_vec++;
        if (total !== m_sum || overflow !== m_ovf || done !== exp_done) begin
            n_fail++;
            $display("FAIL %s: actual total=%h ovf=%b done=%b expected total=%h ovf=%b done=%b",
                     phase, total, overflow, done, m_sum, m_ovf, exp_done);
        end
    endtask

    // Compare, drive one cycle at falling edge, advance model at rising edge
    task automatic step(input logic v, input logic [16:0] w, input logic c);
        compare();
        in_valid = v; in_word = w; restart = c;
        @(posedge clk);
        model_edge(contrib(v, w, c));
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0);
    endtask

    task automatic do_reset();
        ev_t z;
        z = '{vld: 1'b0, clr: 1'b0, val: '0, sat: 1'b0};
        rst_n = 1'b0; in_valid = 1'b0; in_word = '0; restart = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        pipe_q.delete();
        repeat (3) pipe_q.push_back(z);
        m_sum = '0; m_ovf = 1'b0; m_cnt = 0; m_started = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual cycles=200000 expected completion earlier");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        // R8: reset state
        phase = "R8";
        do_reset();
        idle(3);

        // R1 / R2: positive terms across fraction and exponent corners
        phase = "R1";
        step(1'b1, mk(0, 1, 0, 0), 1'b0);
        step(1'b1, mk(0, 1, 0, 255), 1'b0);
        step(1'b1, mk(0, 1, 8, 0), 1'b0);
        step(1'b1, mk(0, 1, 8, 128), 1'b0);
        step(1'b1, mk(0, 1, 20, 77), 1'b0);
        step(1'b1, mk(0, 1, 55, 255), 1'b0);
        phase = "R2";
        idle(5);

        // R9: data without valid is ignored
        phase = "R9";
        step(1'b0, mk(0, 1, 40, 9), 1'b0);
        step(1'b0, mk(1, 1, 60, 200), 1'b0);
        idle(4);

        // R4: negative terms drive the total below zero
        phase = "R4";
        step(1'b1, mk(1, 1, 56 - 1, 255), 1'b0);
        step(1'b1, mk(1, 1, 55, 255), 1'b0);
        step(1'b1, mk(1, 1, 3, 17), 1'b0);
        idle(5);

        // R3: nonzero flag clear adds nothing
        phase = "R3";
        step(1'b1, mk(0, 0, 50, 255), 1'b0);
        step(1'b1, mk(1, 0, 127, 3), 1'b0);
        idle(5);

        // R5: restart with a term, then restart alone
        phase = "R5";
        step(1'b1, mk(0, 1, 10, 10), 1'b1);
        step(1'b1, mk(0, 1, 4, 4), 1'b0);
        idle(5);
        step(1'b0, '0, 1'b1);
        idle(5);

        // R6: clamp sets sticky flag; restart reloads it
        phase = "R6";
        step(1'b1, mk(0, 1, 56, 0), 1'b0);
        step(1'b1, mk(1, 1, 127, 255), 1'b0);
        step(1'b1, mk(0, 1, 2, 2), 1'b0);
        idle(5);
        step(1'b1, mk(0, 1, 5, 5), 1'b1);
        idle(5);
        step(1'b1, mk(0, 1, 90, 1), 1'b1);
        idle(5);

        // R4: large positive stream wraps the 64-bit total
        phase = "R4";
        step(1'b0, '0, 1'b1);
        for (int i = 0; i < 300; i++) step(1'b1, mk(0, 1, 55, 255), 1'b0);
        idle(5);

        // R7: completion flag with gaps between words
        phase = "R7";
        step(1'b1, mk(0, 1, 1, 1), 1'b0);
        idle(2);
        step(1'b1, mk(0, 1, 2, 2), 1'b0);
        idle(6);
        step(1'b0, '0, 1'b1);
        idle(6);

        // R2: pseudo-random stream, compared every cycle
        phase = "R2";
        for (int i = 0; i < 500; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0] | lfsr[1],
                 mk(lfsr[2], lfsr[3] | lfsr[4], int'(lfsr[13:8]) % 60, int'(lfsr[23:16])),
                 lfsr[31:27] == 5'd0);
        end
        idle(6);

        // R8: reset mid-stream returns to the reset state
        phase = "R8";
        step(1'b1, mk(0, 1, 30, 30), 1'b0);
        do_reset();
        idle(4);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule